// File: doc/BRIEF.md
# Variant-Configurable Command Decoder

This block accepts one command per clock from an upstream controller: an 8-bit token and an argument word, qualified by `cmd_valid`. The token selects one of three kinds of handling:

- writing the argument into a parameter register,
- reading a parameter back on `resp_data`,
- firing a one-cycle action strobe.

Every accepted command, known or not, gets exactly one response code one clock later.

A compile-time `VARIANT` parameter selects which commands exist in a given build. A constant lookup table with 256 entries is computed at elaboration. It screens each incoming token: a supported token passes through unchanged, and any other token becomes an internal not-implemented code. The main decode sees only this screened token. A command that belongs to another variant therefore behaves exactly like an undefined token, and the registers that only it could write are removed from the build.

Supported token codes:

- Common to all variants:
  - 0x10 sets the temperature setpoint; 0x11 reads it back.
  - 0x20 sets the gain; 0x21 reads it back.
  - 0x30 fires the capture trigger.
- Variants 0 and 2 only: 0x32 fires the arm strobe.
- Variant 1 only: 0x40 sets the FOO parameter; 0x41 reads it back.
- Variant 2 only: 0x50 sets the BAR parameter; 0x51 reads it back.

Token 0xFF is the internal not-implemented code and is never supported.

Top module: `cmd_decoder_top`

## Requirements
- R1: With `rst_n` low at a rising clock edge, all parameter registers, `resp_valid`, `resp_code` (2'b00), `resp_data`, `trig_pulse` and `arm_pulse` are cleared.
- R2: Each cycle with `cmd_valid` high produces `resp_valid` high for exactly the following cycle. A cycle without `cmd_valid` produces `resp_valid` low and `resp_code` 2'b00 in the following cycle.
- R3: A token that is not supported in the built variant responds 2'b10 with `resp_data` zero. It changes no parameter and fires no strobe.
- R4: A supported set token (0x10, 0x20, 0x40, 0x50) writes `cmd_arg` into its register at the same edge that presents response 2'b01, with `resp_data` zero.
- R5: A supported get token (0x11, 0x21, 0x41, 0x51) returns response 2'b01 with the register's current value on `resp_data`, and changes no register.
- R6: Token 0x30 raises `trig_pulse` for one cycle, coincident with its 2'b01 response.
- R7: Token 0x10 loads `temp_setpt`, which holds its value until the next 0x10 command or a reset.
- R8: FOO (0x40/0x41) exists only in variant 1, BAR (0x50/0x51) only in variant 2, and the arm strobe (0x32) only in variants 0 and 2. In any other variant these tokens respond 2'b10, and `foo_val`/`bar_val` stay zero.
- R9: Back-to-back commands on consecutive cycles are each answered in order. A get that directly follows a set of the same register returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_token | input | 8 | Command token |
| cmd_arg | input | ARG_W | Argument word for set commands |
| resp_valid | output | 1 | Response present, one cycle after the command |
| resp_code | output | 2 | 00 idle, 01 handled, 10 not implemented |
| resp_data | output | ARG_W | Read-back value for get commands, else zero |
| trig_pulse | output | 1 | One-cycle capture trigger strobe |
| arm_pulse | output | 1 | One-cycle arm strobe (variants 0 and 2) |
| temp_setpt | output | ARG_W | Temperature setpoint for the DAC |
| gain_val | output | ARG_W | Gain parameter |
| foo_val | output | ARG_W | Variant-1-only parameter |
| bar_val | output | ARG_W | Variant-2-only parameter |

## Verification
The assertions check the following on every cycle:

- the one-cycle pairing between command and response, and the idle code when no response is presented;
- that a not-implemented response leaves every register and strobe untouched;
- that registers only change alongside a handled response;
- that the parameters foreign to the built variant stay at zero.

The bench covers what needs a reference model. It sweeps all 256 tokens through two builds (variant 1 and variant 2) and compares each build against its own support table. That sweep is what shows the exact mapping of codes to responses, the read-back values, and the set/get ordering in bursts of back-to-back commands.

// File: rtl/cmd_dec_pkg.sv
// Package: token codes, response codes, parameter indices and the
// per-variant support functions used to build the prescreen table.
package cmd_dec_pkg;

    localparam int TOK_W   = 8;
    localparam int NUM_TOK = 1 << TOK_W;
    localparam int NPARAM  = 4;

    localparam logic [1:0] RSP_IDLE = 2'b00;
    localparam logic [1:0] RSP_DONE = 2'b01;
    localparam logic [1:0] RSP_NIMP = 2'b10;

    localparam logic [TOK_W-1:0] TK_SET_TEMP = 8'h10;
    localparam logic [TOK_W-1:0] TK_GET_TEMP = 8'h11;
    localparam logic [TOK_W-1:0] TK_SET_GAIN = 8'h20;
    localparam logic [TOK_W-1:0] TK_GET_GAIN = 8'h21;
    localparam logic [TOK_W-1:0] TK_FIRE     = 8'h30;
    localparam logic [TOK_W-1:0] TK_ARM      = 8'h32;
    localparam logic [TOK_W-1:0] TK_SET_FOO  = 8'h40;
    localparam logic [TOK_W-1:0] TK_GET_FOO  = 8'h41;
    localparam logic [TOK_W-1:0] TK_SET_BAR  = 8'h50;
    localparam logic [TOK_W-1:0] TK_GET_BAR  = 8'h51;
    localparam logic [TOK_W-1:0] TK_NIMP     = 8'hFF;

    localparam int PI_TEMP = 0;
    localparam int PI_GAIN = 1;
    localparam int PI_FOO  = 2;
    localparam int PI_BAR  = 3;

    // True when the token has a handler in the given variant.
    function automatic logic tok_supported(int variant, logic [TOK_W-1:0] tok);
        logic ok;
        case (tok)
            TK_SET_TEMP, TK_GET_TEMP,
            TK_SET_GAIN, TK_GET_GAIN,
            TK_FIRE:                  ok = 1'b1;
            TK_ARM:                   ok = (variant == 0) || (variant == 2);
            TK_SET_FOO, TK_GET_FOO:   ok = (variant == 1);
            TK_SET_BAR, TK_GET_BAR:   ok = (variant == 2);
            default:                  ok = 1'b0;
        endcase
        return ok;
    endfunction

    // True when the parameter register exists in the given variant.
    function automatic logic param_present(int variant, int idx);
        logic ok;
        case (idx)
            PI_FOO:  ok = (variant == 1);
            PI_BAR:  ok = (variant == 2);
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/cmd_prescreen.sv
// Module: cmd_prescreen
// Remaps each token through a constant 256-entry table built at elaboration
// for the selected variant: supported tokens pass, all others become TK_NIMP.
// Assumes: purely combinational, token is valid whenever it is used.
module cmd_prescreen
    import cmd_dec_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic [TOK_W-1:0] tok_in,
    output logic [TOK_W-1:0] tok_out
);

    logic [TOK_W-1:0] screen_lut [NUM_TOK];

    // One constant table entry per possible token value.
    for (genvar g = 0; g < NUM_TOK; g++) begin : g_lut
        localparam logic [TOK_W-1:0] TV = TOK_W'(g);
        assign screen_lut[g] = tok_supported(VARIANT, TV) ? TV : TK_NIMP;
    end

    assign tok_out = screen_lut[tok_in];

endmodule

// File: rtl/cmd_decode.sv
// Module: cmd_decode
// Decodes a screened token into register write enables, a one-hot read
// select, strobe requests and a handled flag.
// Assumes: tok has already been prescreened, so variant checks are not
// repeated here; TK_NIMP and every unknown code fall to the default arm.
module cmd_decode
    import cmd_dec_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [TOK_W-1:0]  tok,
    output logic [NPARAM-1:0] wr_en,
    output logic [NPARAM-1:0] rd_sel,
    output logic              fire_req,
    output logic              arm_req,
    output logic              handled
);

    // Main command case on the screened token.
    always_comb begin
        wr_en    = '0;
        rd_sel   = '0;
        fire_req = 1'b0;
        arm_req  = 1'b0;
        handled  = 1'b0;
        if (cmd_valid) begin
            case (tok)
                TK_SET_TEMP: begin wr_en[PI_TEMP]  = 1'b1; handled = 1'b1; end
                TK_GET_TEMP: begin rd_sel[PI_TEMP] = 1'b1; handled = 1'b1; end
                TK_SET_GAIN: begin wr_en[PI_GAIN]  = 1'b1; handled = 1'b1; end
                TK_GET_GAIN: begin rd_sel[PI_GAIN] = 1'b1; handled = 1'b1; end
                TK_SET_FOO:  begin wr_en[PI_FOO]   = 1'b1; handled = 1'b1; end
                TK_GET_FOO:  begin rd_sel[PI_FOO]  = 1'b1; handled = 1'b1; end
                TK_SET_BAR:  begin wr_en[PI_BAR]   = 1'b1; handled = 1'b1; end
                TK_GET_BAR:  begin rd_sel[PI_BAR]  = 1'b1; handled = 1'b1; end
                TK_FIRE:     begin fire_req        = 1'b1; handled = 1'b1; end
                TK_ARM:      begin arm_req         = 1'b1; handled = 1'b1; end
                default:     handled = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/cmd_param_bank.sv
// Module: cmd_param_bank
// Holds the parameter registers. Registers absent from the variant are
// tied to zero, so no storage is built for them.
// Assumes: wr_en is at most one-hot; synchronous active-low reset.
module cmd_param_bank
    import cmd_dec_pkg::*;
#(
    parameter int VARIANT = 0,
    parameter int ARG_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPARAM-1:0]            wr_en,
    input  logic [ARG_W-1:0]             wr_data,
    output logic [NPARAM-1:0][ARG_W-1:0] params
);

    for (genvar p = 0; p < NPARAM; p++) begin : g_param
        if (param_present(VARIANT, p)) begin : g_reg
            logic [ARG_W-1:0] q;
            // Parameter storage: cleared by reset, loaded on its write enable.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en[p])
                    q <= wr_data;
            end
            assign params[p] = q;
        end else begin : g_tie
            logic unused_en;
            assign unused_en = wr_en[p];
            assign params[p] = '0;
        end
    end

endmodule

// File: rtl/cmd_resp_gen.sv
// Module: cmd_resp_gen
// Registers the response code, read-back data and action strobes, so that
// all of them appear one clock after the command.
// Assumes: rd_data is zero when no read is selected.
module cmd_resp_gen
    import cmd_dec_pkg::*;
#(
    parameter int ARG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             handled,
    input  logic [ARG_W-1:0] rd_data,
    input  logic             fire_req,
    input  logic             arm_req,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    output logic [ARG_W-1:0] resp_data,
    output logic             trig_pulse,
    output logic             arm_pulse
);

    // Response and strobe register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RSP_IDLE;
            resp_data  <= '0;
            trig_pulse <= 1'b0;
            arm_pulse  <= 1'b0;
        end else begin
            resp_valid <= cmd_valid;
            resp_code  <= !cmd_valid ? RSP_IDLE : (handled ? RSP_DONE : RSP_NIMP);
            resp_data  <= rd_data;
            trig_pulse <= fire_req;
            arm_pulse  <= arm_req;
        end
    end

endmodule

// File: rtl/cmd_decoder_top.sv
// Module: cmd_decoder_top
// Command decoder whose command set is chosen by VARIANT. Data path:
// prescreen table -> decode -> parameter bank / response registers.
// Assumes: one command per cycle with cmd_valid; no backpressure.
module cmd_decoder_top
    import cmd_dec_pkg::*;
#(
    parameter int VARIANT = 0,
    parameter int ARG_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_token,
    input  logic [ARG_W-1:0] cmd_arg,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    output logic [ARG_W-1:0] resp_data,
    output logic             trig_pulse,
    output logic             arm_pulse,
    output logic [ARG_W-1:0] temp_setpt,
    output logic [ARG_W-1:0] gain_val,
    output logic [ARG_W-1:0] foo_val,
    output logic [ARG_W-1:0] bar_val
);

    logic [TOK_W-1:0]             tok_scr;
    logic [NPARAM-1:0]            wr_en;
    logic [NPARAM-1:0]            rd_sel;
    logic                         fire_req;
    logic                         arm_req;
    logic                         handled;
    logic [NPARAM-1:0][ARG_W-1:0] params;
    logic [ARG_W-1:0]             rd_data;

    cmd_prescreen #(.VARIANT(VARIANT)) screen_i (
        .tok_in  (cmd_token),
        .tok_out (tok_scr)
    );

    cmd_decode decode_i (
        .cmd_valid (cmd_valid),
        .tok       (tok_scr),
        .wr_en     (wr_en),
        .rd_sel    (rd_sel),
        .fire_req  (fire_req),
        .arm_req   (arm_req),
        .handled   (handled)
    );

    cmd_param_bank #(.VARIANT(VARIANT), .ARG_W(ARG_W)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (cmd_arg),
        .params  (params)
    );

    // Read-back mux: OR of the registers selected by the one-hot read select.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NPARAM; p++) begin
            if (rd_sel[p])
                rd_data = rd_data | params[p];
        end
    end

    cmd_resp_gen #(.ARG_W(ARG_W)) resp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .handled    (handled),
        .rd_data    (rd_data),
        .fire_req   (fire_req),
        .arm_req    (arm_req),
        .resp_valid (resp_valid),
        .resp_code  (resp_code),
        .resp_data  (resp_data),
        .trig_pulse (trig_pulse),
        .arm_pulse  (arm_pulse)
    );

    assign temp_setpt = params[PI_TEMP];
    assign gain_val   = params[PI_GAIN];
    assign foo_val    = params[PI_FOO];
    assign bar_val    = params[PI_BAR];

endmodule

// File: rtl/cmd_decoder_chk.sv
// Module: cmd_decoder_chk
// Property checker bound to cmd_decoder_top; watches only its ports.
module cmd_decoder_chk #(
    parameter int VARIANT = 0,
    parameter int ARG_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             resp_valid,
    input logic [1:0]       resp_code,
    input logic [ARG_W-1:0] resp_data,
    input logic             trig_pulse,
    input logic             arm_pulse,
    input logic [ARG_W-1:0] temp_setpt,
    input logic [ARG_W-1:0] gain_val,
    input logic [ARG_W-1:0] foo_val,
    input logic [ARG_W-1:0] bar_val
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!resp_valid && resp_code == 2'b00 && !trig_pulse && !arm_pulse
                    && temp_setpt == '0 && gain_val == '0 && foo_val == '0 && bar_val == '0));

    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> resp_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !resp_valid);

    assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> resp_code == 2'b00);

    assert_nimp_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'b10) |->
            ($stable(temp_setpt) && $stable(gain_val) && $stable(foo_val) && $stable(bar_val)
             && !trig_pulse && !arm_pulse && resp_data == '0));

    assert_gain_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_val) |-> (resp_valid && resp_code == 2'b01));

    assert_trig_handled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (resp_valid && resp_code == 2'b01));

    assert_temp_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(temp_setpt) |-> (resp_valid && resp_code == 2'b01));

    if (VARIANT != 1) begin : g_no_foo
        assert_foo_pruned_R8: assert property (@(posedge clk) disable iff (!rst_n)
            foo_val == '0);
    end
    if (VARIANT != 2) begin : g_no_bar
        assert_bar_pruned_R8: assert property (@(posedge clk) disable iff (!rst_n)
            bar_val == '0);
    end
    if (VARIANT == 1) begin : g_no_arm
        assert_arm_pruned_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !arm_pulse);
    end

endmodule

bind cmd_decoder_top cmd_decoder_chk #(.VARIANT(VARIANT), .ARG_W(ARG_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .resp_data  (resp_data),
    .trig_pulse (trig_pulse),
    .arm_pulse  (arm_pulse),
    .temp_setpt (temp_setpt),
    .gain_val   (gain_val),
    .foo_val    (foo_val),
    .bar_val    (bar_val)
);

// File: tb/cmd_decoder_top_tb_top.sv
`timescale 1ns/1ps
// Bench: two builds (variant 1 and variant 2) driven in parallel, each checked
// against its own independent support table and register model.
module cmd_decoder_top_tb_top;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_token = '0;
    logic [AW-1:0] cmd_arg = '0;

    logic          rv   [2];
    logic [1:0]    rc   [2];
    logic [AW-1:0] rd   [2];
    logic          trg  [2];
    logic          arm  [2];
    logic [AW-1:0] prm  [2][4];

    int  n_checks = 0;
    int  n_err    = 0;
    bit  done     = 1'b0;
    int  vv [2]   = '{1, 2};
    logic [AW-1:0] ex [2][4];

    always #10 clk = ~clk;

    cmd_decoder_top #(.VARIANT(1), .ARG_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_token(cmd_token),
        .cmd_arg(cmd_arg), .resp_valid(rv[0]), .resp_code(rc[0]), .resp_data(rd[0]),
        .trig_pulse(trg[0]), .arm_pulse(arm[0]), .temp_setpt(prm[0][0]),
        .gain_val(prm[0][1]), .foo_val(prm[0][2]), .bar_val(prm[0][3]));

    cmd_decoder_top #(.VARIANT(2), .ARG_W(AW)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_token(cmd_token),
        .cmd_arg(cmd_arg), .resp_valid(rv[1]), .resp_code(rc[1]), .resp_data(rd[1]),
        .trig_pulse(trg[1]), .arm_pulse(arm[1]), .temp_setpt(prm[1][0]),
        .gain_val(prm[1][1]), .foo_val(prm[1][2]), .bar_val(prm[1][3]));

    function automatic bit ex_sup(int v, logic [7:0] t);
        case (t)
            8'h10, 8'h11, 8'h20, 8'h21, 8'h30: return 1'b1;
            8'h32:                             return (v == 0) || (v == 2);
            8'h40, 8'h41:                      return v == 1;
            8'h50, 8'h51:                      return v == 2;
            default:                           return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, string ctx, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s (%s): actual %h expected %h", tag, ctx, act, exp);
        end
    endtask

    // Drive one cycle of stimulus (called at a falling edge), then check at the next.
    task automatic do_cmd(bit v, logic [7:0] t, logic [AW-1:0] a, string ctx);
        cmd_valid = v; cmd_token = t; cmd_arg = a;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            bit sup = v && ex_sup(vv[k], t);
            logic [1:0] e_code = !v ? 2'b00 : (sup ? 2'b01 : 2'b10);
            logic [AW-1:0] e_data = '0;
            string ptag;
            if (sup) begin
                case (t)
                    8'h10: ex[k][0] = a;
                    8'h11: e_data = ex[k][0];
                    8'h20: ex[k][1] = a;
                    8'h21: e_data = ex[k][1];
                    8'h40: ex[k][2] = a;
                    8'h41: e_data = ex[k][2];
                    8'h50: ex[k][3] = a;
                    8'h51: e_data = ex[k][3];
                    default: ;
                endcase
            end
            check("R2", ctx, 32'(rv[k]), 32'(v));
            check(!v ? "R2" : (sup ? "R4" : "R3"), ctx, 32'(rc[k]), 32'(e_code));
            check("R5", ctx, 32'(rd[k]), 32'(e_data));
            check("R6", ctx, 32'(trg[k]), 32'(sup && t == 8'h30));
            check("R8", ctx, 32'(arm[k]), 32'(sup && t == 8'h32));
            for (int p = 0; p < 4; p++) begin
                ptag = (p == 0) ? "R7" : (p == 1) ? "R4" : "R8";
                check(ptag, ctx, 32'(prm[k][p]), 32'(ex[k][p]));
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            check("R1", "reset", 32'({rv[k], rc[k], trg[k], arm[k]}), 32'h0);
            check("R1", "reset data", 32'(rd[k]), 32'h0);
            for (int p = 0; p < 4; p++) begin
                check("R1", "reset param", 32'(prm[k][p]), 32'h0);
                ex[k][p] = '0;
            end
        end
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        do_reset();
        // Preload every register so foreign writes would be visible.
        do_cmd(1, 8'h10, 16'h0A0A, "R7 preload");
        do_cmd(1, 8'h20, 16'h0B0B, "R4 preload");
        do_cmd(1, 8'h40, 16'h0C0C, "R8 preload foo");
        do_cmd(1, 8'h50, 16'h0D0D, "R8 preload bar");
        // R3 R8: exhaustive token sweep with an idle cycle after each.
        for (int t = 0; t < 256; t++) begin
            do_cmd(1, 8'(t), {8'(t), ~8'(t)}, "sweep");
            do_cmd(0, 8'(t), 16'hFFFF, "R2 idle");
        end
        // R9: back-to-back burst, get right after set.
        do_cmd(1, 8'h10, 16'h1234, "R9 burst");
        do_cmd(1, 8'h11, 16'h0000, "R9 burst");
        do_cmd(1, 8'h30, 16'h0000, "R9 burst");
        do_cmd(1, 8'h30, 16'h0000, "R9 burst");
        do_cmd(1, 8'h20, 16'hBEEF, "R9 burst");
        do_cmd(1, 8'h21, 16'h5555, "R9 burst");
        do_cmd(1, 8'h41, 16'h0000, "R9 burst");
        do_cmd(1, 8'h51, 16'h0000, "R9 burst");
        do_cmd(1, 8'h32, 16'h0000, "R9 burst");
        do_cmd(1, 8'hFF, 16'h7777, "R3 nimp code");
        do_cmd(0, 8'h00, 16'h0000, "R2 idle");
        // R1: reset mid-run clears everything again.
        @(negedge clk);
        do_reset();
        do_cmd(1, 8'h11, 16'h0000, "R1 after reset");
        do_cmd(1, 8'h41, 16'h0000, "R1 after reset");
        do_cmd(0, 8'h00, 16'h0000, "R2 idle");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule